// File: doc/BRIEF.md
# Clock Multiplier Switch Controller

This block governs the move of a protocol core from its bypass clock (the 20 MHz reference, good for rates up to 2.5 Mbps) to a doubled clock of 40 MHz (for rates up to 5 Mbps) produced by an on-chip multiplier. After hardware reset the multiplier is powered down and bypassed, and the core runs. The host changes the clock through a setup register. The block then stops the core, turns on the multiplier and holds the core stopped through a settling interval.

The interval is counted in local clock cycles. It is sized for the specified 1 ms wait, far longer than the multiplier's typical lock time of about 8 µs. The clock select moves over only at the end of the interval, with the core still stopped, and only if the multiplier reports lock. The core starts again only when the host writes the restart code to the command register after that point. Only one change of the clock selection is accepted per hardware reset. Any later request to change it is refused and raises a sticky error flag.

The multiplier itself is outside the block. It is seen only through its enable output and its lock input.

Top module: `clkmul_switch_ctrl`

## Requirements
- R1: While reset is held and after it is released, core_run is 1, clk_sel is 0, pll_en is 0 and chg_err is 0.
- R2: A host write with host_wr_sel = 0 (setup register) and data bit 0 = 1, as the first change since reset, sets core_run to 0 and pll_en to 1 after the next clock edge.
- R3: A setup write whose bit 0 equals the current selection has no effect on any output. Data bits 7:1 of a setup write are ignored, and such a write does not use up the single allowed change.
- R4: After an accepted change written at edge E0, with pll_lock high, clk_sel is still 0 after edge E0+SETTLE_CYCLES and becomes 1 after edge E0+SETTLE_CYCLES+1. clk_sel changes only while core_run is 0, both before and after the change.
- R5: While pll_lock is low, the block stays halted and clk_sel keeps its value, however long the settling count has run.
- R6: Once clk_sel has switched, a write with host_wr_sel = 1 (command register) and data 0x18 sets core_run to 1 after that edge.
- R7: A restart write that arrives before clk_sel has switched is ignored, and the core stays halted until a later restart write.
- R8: Command writes of any value other than 0x18 are ignored. A command write while the core runs has no effect.
- R9: A setup write that would change the selection again after a change has been accepted leaves pll_en, clk_sel and core_run unchanged and sets chg_err, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_wr_sel | input | 1 | Register select: 0 setup, 1 command |
| host_wr_data | input | 8 | Host write data |
| pll_lock | input | 1 | Lock indication from the multiplier |
| pll_en | output | 1 | Multiplier power enable |
| clk_sel | output | 1 | Core clock select: 0 bypass, 1 multiplied |
| core_run | output | 1 | Protocol core run enable |
| chg_err | output | 1 | Sticky flag for a refused second change |

## Verification
The hardest case to reach is the one-cycle boundary where a restart write lands on the edge just before or just after the block becomes ready. That point depends on the settling count, the lock input and the edge of the setup write all together. The bench builds the block with a short settling count. It then sweeps the delay between the setup write and the restart write across every cycle from one to past the boundary, with a fresh reset each time. For each delay it predicts by arithmetic whether the restart is taken. Holding lock low while the count expires reaches the second hidden state, counter done but not ready.

// File: rtl/clkmul_pkg.sv
// Shared types for the clock multiplier switch controller.
// Assumes a single host write port with a one-bit register select.
package clkmul_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2
    } clkmul_state_e;

    localparam logic WSEL_SETUP = 1'b0;
    localparam logic WSEL_CMD   = 1'b1;
endpackage

// File: rtl/clkmul_host_decode.sv
// Decodes one host write into setup and restart events.
// Assumes the write strobe is high for exactly one cycle per write.
module clkmul_host_decode
    import clkmul_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter int                SEL_BIT      = 0,
    parameter logic [DATA_W-1:0] RESTART_CODE = 8'h18
) (
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              setup_wr,
    output logic              setup_val,
    output logic              restart_req
);
    // Split the write by target register and pick out the field that matters.
    always_comb begin
        setup_wr    = wr_en && (wr_sel == WSEL_SETUP);
        setup_val   = wr_data[SEL_BIT];
        restart_req = wr_en && (wr_sel == WSEL_CMD) && (wr_data == RESTART_CODE);
    end
endmodule

// File: rtl/clkmul_settle_timer.sv
// Counts the settling wait after a clock change and saturates at the limit.
// Assumes clear takes priority over counting; done stays high until cleared.
module clkmul_settle_timer #(
    parameter int SETTLE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic done
);
    localparam int              CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Count enabled cycles up to the limit, restarting from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (enable && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Signal that the full interval has passed.
    always_comb done = (cnt_q == LIMIT);
endmodule

// File: rtl/clkmul_change_guard.sv
// Allows one change of the clock selection per reset and flags any further one.
// Assumes a write that repeats the current target is neither a change nor an error.
module clkmul_change_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_wr,
    input  logic setup_val,
    output logic accept,
    output logic target,
    output logic err
);
    logic used_q;
    logic differs;

    // Classify a setup write as a first change or a refused later one.
    always_comb begin
        differs = setup_wr && (setup_val != target);
        accept  = differs && !used_q;
    end

    // Record the target, the spent change and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= 1'b0;
            used_q <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (accept) begin
                target <= setup_val;
                used_q <= 1'b1;
            end
            if (differs && used_q) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkmul_switch_ctrl.sv
// Top of the clock multiplier switch controller: stops the core, powers the
// multiplier, waits out the settling time, swaps the clock while halted and
// resumes on the restart command. Assumes a synchronous active-low reset.
module clkmul_switch_ctrl
    import clkmul_pkg::*;
#(
    parameter int                DATA_W        = 8,
    parameter int                SEL_BIT       = 0,
    parameter logic [DATA_W-1:0] RESTART_CODE  = 8'h18,
    parameter int                SETTLE_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_sel,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              pll_lock,
    output logic              pll_en,
    output logic              clk_sel,
    output logic              core_run,
    output logic              chg_err
);
    clkmul_state_e state_q;
    logic setup_wr, setup_val, restart_req;
    logic accept, target, settle_done;

    clkmul_host_decode #(
        .DATA_W      (DATA_W),
        .SEL_BIT     (SEL_BIT),
        .RESTART_CODE(RESTART_CODE)
    ) decode_i (
        .wr_en      (host_wr_en),
        .wr_sel     (host_wr_sel),
        .wr_data    (host_wr_data),
        .setup_wr   (setup_wr),
        .setup_val  (setup_val),
        .restart_req(restart_req)
    );

    clkmul_change_guard guard_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .setup_wr (setup_wr),
        .setup_val(setup_val),
        .accept   (accept),
        .target   (target),
        .err      (chg_err)
    );

    clkmul_settle_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .enable(state_q == ST_SETTLE),
        .done  (settle_done)
    );

    // Sequence halt, settle, clock swap and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pll_en  <= 1'b0;
            clk_sel <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (accept) begin
                        state_q <= ST_SETTLE;
                        pll_en  <= setup_val;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done && pll_lock) begin
                        state_q <= ST_READY;
                        clk_sel <= target;
                    end
                end
                ST_READY: begin
                    if (restart_req) begin
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // The core runs only in the run state.
    always_comb core_run = (state_q == ST_RUN);
endmodule

// File: rtl/clkmul_switch_ctrl_chk.sv
// Property checker for the clock multiplier switch controller, bound to the top.
module clkmul_switch_ctrl_chk #(
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-1:0] RESTART_CODE = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic              host_wr_sel,
    input logic [DATA_W-1:0] host_wr_data,
    input logic              pll_lock,
    input logic              pll_en,
    input logic              clk_sel,
    input logic              core_run,
    input logic              chg_err
);
    // R4
    clksel_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel)) |-> (!core_run && !$past(core_run)));

    // R5
    clksel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel) |-> $past(pll_lock));

    // R6
    restart_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> $past(host_wr_en && host_wr_sel && (host_wr_data == RESTART_CODE)));

    // R2
    halt_powers_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_run) |-> pll_en);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(chg_err));

    // R4
    sel_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel |-> pll_en);
endmodule

bind clkmul_switch_ctrl clkmul_switch_ctrl_chk #(
    .DATA_W      (DATA_W),
    .RESTART_CODE(RESTART_CODE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr_en  (host_wr_en),
    .host_wr_sel (host_wr_sel),
    .host_wr_data(host_wr_data),
    .pll_lock    (pll_lock),
    .pll_en      (pll_en),
    .clk_sel     (clk_sel),
    .core_run    (core_run),
    .chg_err     (chg_err)
);

// File: tb/clkmul_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkmul_switch_ctrl_tb_top;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic       host_wr_sel = 1'b0;
    logic [7:0] host_wr_data = 8'h00;
    logic       pll_lock = 1'b1;
    logic       pll_en, clk_sel, core_run, chg_err;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clkmul_switch_ctrl #(.SETTLE_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
        .host_wr_data(host_wr_data), .pll_lock(pll_lock), .pll_en(pll_en),
        .clk_sel(clk_sel), .core_run(core_run), .chg_err(chg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
        tick();
        host_wr_en = 1'b0; host_wr_data = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; host_wr_en = 1'b0; pll_lock = 1'b1;
        tick(); tick();
        chk("R1 core_run in reset", core_run, 1);
        chk("R1 clk_sel in reset", clk_sel, 0);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        do_reset();
        chk("R1 core_run", core_run, 1);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 pll_en", pll_en, 0);
        chk("R1 chg_err", chg_err, 0);

        // R8: every command value while running leaves everything alone
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'(v));
            chk("R8 run cmd core_run", core_run, 1);
            chk("R8 run cmd pll_en", pll_en, 0);
        end
        // R3: setup writes with bit 0 clear are no-ops whatever the upper bits
        for (int v = 0; v < 256; v += 2) begin
            wr(1'b0, 8'(v));
            chk("R3 core_run", core_run, 1);
            chk("R3 pll_en", pll_en, 0);
            chk("R3 chg_err", chg_err, 0);
        end
        wr(1'b0, 8'hFF);
        chk("R3 change still available", core_run, 0);

        // R4 R6 R7: sweep the restart delay across the ready boundary
        for (int d = 1; d <= S + 4; d++) begin
            do_reset();
            wr(1'b0, 8'hA1);
            chk("R2 halted", core_run, 0);
            chk("R2 pll_en", pll_en, 1);
            for (int i = 1; i < d; i++) begin
                tick();
                chk("R4 clk_sel timing", clk_sel, (i >= S + 1) ? 1 : 0);
                chk("R4 halted while settling", core_run, 0);
            end
            wr(1'b1, 8'h18);
            chk(d >= S + 2 ? "R6 restart taken" : "R7 early restart ignored",
                core_run, (d >= S + 2) ? 1 : 0);
            if (d < S + 2) begin
                for (int i = d; i < S + 1; i++) tick();
                chk("R7 still halted", core_run, 0);
                wr(1'b1, 8'h18);
                chk("R6 later restart", core_run, 1);
            end
            chk("R4 clk_sel final", clk_sel, 1);
        end

        // R5: lock held low keeps the block halted past the count
        do_reset();
        pll_lock = 1'b0;
        wr(1'b0, 8'h01);
        repeat (S + 5) tick();
        chk("R5 clk_sel held", clk_sel, 0);
        chk("R5 still halted", core_run, 0);
        wr(1'b1, 8'h18);
        chk("R7 restart without lock ignored", core_run, 0);
        // R8: wrong command values while ready
        pll_lock = 1'b1;
        tick();
        chk("R4 clk_sel after lock", clk_sel, 1);
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h18) begin
                wr(1'b1, 8'(v));
                chk("R8 wrong code ignored", core_run, 0);
            end
        end
        wr(1'b1, 8'h18);
        chk("R6 restart after lock", core_run, 1);

        // R9: second change refused, flag sticky
        wr(1'b0, 8'h00);
        chk("R9 chg_err set", chg_err, 1);
        chk("R9 clk_sel kept", clk_sel, 1);
        chk("R9 pll_en kept", pll_en, 1);
        chk("R9 core_run kept", core_run, 1);
        wr(1'b0, 8'h01);
        chk("R9 chg_err sticky", chg_err, 1);
        chk("R9 no halt on same value", core_run, 1);

        // R9: refused change while settling leaves the sequence intact
        do_reset();
        chk("R1 chg_err cleared", chg_err, 0);
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h00);
        chk("R9 err while halted", chg_err, 1);
        chk("R9 pll_en kept while halted", pll_en, 1);
        repeat (S) tick();
        chk("R9 clk_sel switched anyway", clk_sel, 1);
        wr(1'b1, 8'h18);
        chk("R9 restart still works", core_run, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule